// File: doc/BRIEF.md
# Programmable ROM Mode Controller

This block models a word-wide programmable read-only memory together with its control-pin mode logic. Each clock it decodes an active-low chip enable, an active-low output enable, a flag for the programming supply being present and a flag for the high voltage on the identifier address pin. From these it picks one of seven modes: read, output disable, standby, program, verify, program inhibit or signature. The data bus is modelled as a registered data word plus a drive-enable flag. While the drive-enable is low, the data word is held at zero.

The storage array is DATA_W bits wide and 2**ADDR_W words deep. Reset brings it to the blank state, with every bit one. A program operation merges new data into a word by bitwise AND, so bits can only be cleared. Each low pulse on chip enable writes once. An erase input returns the whole array to ones, but only in the erasable build (ERASABLE=1). The one-time build ignores it. The signature mode returns two fixed identifier bytes, selected by address bit 0.

Top module: `prom_ctrl`

## Requirements
- R1: After reset data_oe_o is 0, data_o is 0 and every word of the array reads 16'hFFFF.
- R2: With vpp_i=0, hv_i=0, ce_n_i=0 and oe_n_i=0 (read), the cycle after, data_oe_o=1 and data_o equals the stored word at addr_i.
- R3: With vpp_i=0, ce_n_i=0 and oe_n_i=1 (output disable), the cycle after, data_oe_o=0 and data_o=0.
- R4: With vpp_i=0 and ce_n_i=1 (standby), the cycle after, data_oe_o=0 and data_o=0.
- R5: With vpp_i=1 and oe_n_i=1, the first cycle in which ce_n_i is low (after a cycle with it high) writes data_i into the word at addr_i. Later low cycles of the same pulse write nothing. Outputs stay undriven during programming.
- R6: With vpp_i=1, ce_n_i=1 and oe_n_i=0 (verify), the cycle after, data_oe_o=1 and data_o equals the stored word at addr_i.
- R7: With vpp_i=1 and ce_n_i equal to oe_n_i (both high, or both low), nothing is written and the outputs are undriven.
- R8: With vpp_i=0, hv_i=1, ce_n_i=0 and oe_n_i=0 (signature), data_o reads 16'h0097 when addr_i[0]=0 and 16'h0030 when addr_i[0]=1. The upper 8 bits are zero and data_oe_o=1.
- R9: A program stores the old word AND data_i, so a bit at zero never returns to one through programming.
- R10: With ERASABLE=1, erase_i high at a clock edge sets every word to all ones. With ERASABLE=0, erase_i has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Chip enable, active low; a low pulse programs |
| oe_n_i | input | 1 | Output enable, active low |
| vpp_i | input | 1 | Programming supply present |
| hv_i | input | 1 | High voltage present on the identifier address pin |
| erase_i | input | 1 | Whole-array erase (erasable build only) |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Program data |
| data_o | output | DATA_W | Output data, zero when not driven |
| data_oe_o | output | 1 | Output drive enable |

## Verification
Every output result is registered once. Mode, data and drive-enable are therefore due one cycle after the inputs that select them. A program or erase takes effect at the edge that samples it, so a read issued in the following cycle shows the new word. The bench changes inputs on the falling edge and samples at the next falling edge. It sweeps all addresses with two layered program patterns, checks the disable, standby, inhibit and signature modes in turn, and compares an erasable instance against a one-time instance.

// File: rtl/prom_pkg.sv
package prom_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DISABLE,
    MODE_READ,
    MODE_SIG,
    MODE_PROG,
    MODE_VERIFY,
    MODE_INHIBIT
  } mode_e;
endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
  import prom_pkg::*;
(
  input  logic  ce_n_i,
  input  logic  oe_n_i,
  input  logic  vpp_i,
  input  logic  hv_i,
  output mode_e mode_o
);
  always_comb begin
    if (vpp_i) begin
      if (!ce_n_i && oe_n_i)      mode_o = MODE_PROG;
      else if (ce_n_i && !oe_n_i) mode_o = MODE_VERIFY;
      else                        mode_o = MODE_INHIBIT;
    end else if (ce_n_i) begin
      mode_o = MODE_STANDBY;
    end else if (oe_n_i) begin
      mode_o = MODE_DISABLE;
    end else if (hv_i) begin
      mode_o = MODE_SIG;
    end else begin
      mode_o = MODE_READ;
    end
  end
endmodule

// File: rtl/prom_array.sv
module prom_array #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter bit ERASABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              erase_en;

  generate
    if (ERASABLE) begin : g_erasable
      assign erase_en = erase_i;
    end else begin : g_otp
      assign erase_en = 1'b0;
    end
  endgenerate

  // reset models a blank part
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (erase_en) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en_i) begin
      mem[addr_i] <= mem[addr_i] & wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];

  AST_PROG_CLEAR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !erase_en |=> (mem[$past(addr_i)] & ~$past(rdata_o)) == '0); // R9
  AST_ERASE_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_en |=> &mem[$past(addr_i)]); // R10
endmodule

// File: rtl/prom_out_stage.sv
module prom_out_stage
  import prom_pkg::*;
#(
  parameter int         DATA_W = 16,
  parameter logic [7:0] MFG_ID = 8'h97,
  parameter logic [7:0] DEV_ID = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int PAD_W = DATA_W - 8;

  logic [DATA_W-1:0] nxt_data;
  logic              nxt_oe;

  always_comb begin
    nxt_data = '0;
    nxt_oe   = 1'b0;
    unique case (mode_i)
      MODE_READ, MODE_VERIFY: begin
        nxt_data = word_i;
        nxt_oe   = 1'b1;
      end
      MODE_SIG: begin
        nxt_data = {{PAD_W{1'b0}}, (sel_i ? DEV_ID : MFG_ID)};
        nxt_oe   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      data_o    <= nxt_data;
      data_oe_o <= nxt_oe;
    end
  end
endmodule

// File: rtl/prom_ctrl.sv
module prom_ctrl
  import prom_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter int         DATA_W   = 16,
  parameter bit         ERASABLE = 1'b1,
  parameter logic [7:0] MFG_ID   = 8'h97,
  parameter logic [7:0] DEV_ID   = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              vpp_i,
  input  logic              hv_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  mode_e             mode;
  logic              ce_n_q;
  logic              wr_en;
  logic [DATA_W-1:0] word;

  prom_mode_dec u_dec (
    .ce_n_i (ce_n_i),
    .oe_n_i (oe_n_i),
    .vpp_i  (vpp_i),
    .hv_i   (hv_i),
    .mode_o (mode)
  );

  // one write per chip-enable low pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_n_q <= 1'b1;
    else         ce_n_q <= ce_n_i;
  end

  assign wr_en = (mode == MODE_PROG) && ce_n_q;

  prom_array #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ERASABLE (ERASABLE)
  ) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .erase_i (erase_i),
    .addr_i  (addr_i),
    .wdata_i (data_i),
    .rdata_o (word)
  );

  prom_out_stage #(
    .DATA_W (DATA_W),
    .MFG_ID (MFG_ID),
    .DEV_ID (DEV_ID)
  ) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .sel_i     (addr_i[0]),
    .word_i    (word),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpp_i && !ce_n_i && !oe_n_i |=> data_oe_o); // R2
  AST_DISABLE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_n_i && oe_n_i |=> !data_oe_o && data_o == '0); // R3
  AST_STANDBY_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpp_i && ce_n_i |=> !data_oe_o && data_o == '0); // R4
  AST_ONE_WRITE_PER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !wr_en); // R5
  AST_VERIFY_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpp_i && ce_n_i && !oe_n_i |=> data_oe_o); // R6
  AST_INHIBIT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpp_i && (ce_n_i == oe_n_i) |-> !wr_en); // R7
  AST_SIG_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_i && !vpp_i && !ce_n_i && !oe_n_i |=> data_oe_o && data_o[DATA_W-1:8] == '0); // R8
endmodule

// File: tb/prom_ctrl_test.sv
`timescale 1ns/1ps
module prom_ctrl_test;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int N  = 2 ** AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp = 1'b0, hv = 1'b0, erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout, dout_otp;
  logic          doe, doe_otp;
  logic [DW-1:0] exp_mem [N];
  int            n_chk = 0;
  int            n_fail = 0;

  always #10 clk = ~clk;

  prom_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERASABLE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_n_i(ce_n), .oe_n_i(oe_n), .vpp_i(vpp),
    .hv_i(hv), .erase_i(erase), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(doe));

  prom_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERASABLE(1'b0)) uut_otp (
    .clk_i(clk), .rst_ni(rst_ni), .ce_n_i(ce_n), .oe_n_i(oe_n), .vpp_i(vpp),
    .hv_i(hv), .erase_i(erase), .addr_i(addr), .data_i(din),
    .data_o(dout_otp), .data_oe_o(doe_otp));

  task automatic check(input string tag, input logic [DW:0] got, input logic [DW:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // apply inputs at a falling edge, return at the next falling edge
  task automatic cyc(input logic c, input logic o, input logic v, input logic h,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n = c; oe_n = o; vpp = v; hv = h; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1, 1, 1, 0, a, d);
    cyc(0, 1, 1, 0, a, d);
    check("R5 undriven while programming", {doe, dout}, '0);
    cyc(1, 1, 1, 0, a, d);
    exp_mem[a] = exp_mem[a] & d;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a);
    cyc(0, 0, 0, 0, a, '0);
    check(tag, {doe, dout}, {1'b1, exp_mem[a]});
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) exp_mem[i] = '1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    check("R1 reset outputs", {doe, dout}, '0);
    check("R1 reset otp outputs", {doe_otp, dout_otp}, '0);

    for (int a = 0; a < N; a++) rd("R1 R2 blank read", AW'(a));

    for (int a = 0; a < N; a++) prog(AW'(a), DW'(a * 16'h0421) ^ 16'h5AF3);
    for (int a = 0; a < N; a++) rd("R2 R5 read after program", AW'(a));
    for (int a = 0; a < N; a += 5) begin
      cyc(1, 0, 1, 0, AW'(a), '0);
      check("R6 verify", {doe, dout}, {1'b1, exp_mem[a]});
    end

    for (int a = 0; a < N; a++) prog(AW'(a), ~DW'(a * 16'h1111) | 16'h8001);
    for (int a = 0; a < N; a++) rd("R9 ones never return", AW'(a));
    prog(AW'(9), 16'hFFFF);
    rd("R9 all-ones program keeps zeros", AW'(9));

    // R5: data changing within one pulse is not written
    cyc(1, 1, 1, 0, 5, 16'h00FF);
    cyc(0, 1, 1, 0, 5, 16'h00FF);
    cyc(0, 1, 1, 0, 5, 16'h0000);
    cyc(0, 1, 1, 0, 5, 16'h0000);
    cyc(1, 1, 1, 0, 5, 16'h0000);
    exp_mem[5] = exp_mem[5] & 16'h00FF;
    rd("R5 single write per pulse", 5);

    // R7 inhibit
    for (int k = 0; k < 3; k++) begin
      cyc(1, 1, 1, 0, 7, '0);
      check("R7 inhibit undriven", {doe, dout}, '0);
    end
    cyc(0, 0, 1, 0, 7, '0);
    check("R7 both low undriven", {doe, dout}, '0);
    cyc(1, 1, 1, 0, 7, '0);
    rd("R7 inhibit no write", 7);

    cyc(0, 1, 0, 0, 3, '0);
    check("R3 output disable", {doe, dout}, '0);
    cyc(0, 1, 0, 1, 3, '0);
    check("R3 disable with hv", {doe, dout}, '0);
    cyc(1, 0, 0, 0, 3, '0);
    check("R4 standby", {doe, dout}, '0);
    cyc(1, 1, 0, 1, 3, '0);
    check("R4 standby with hv", {doe, dout}, '0);

    cyc(0, 0, 0, 1, 0, '0);
    check("R8 manufacturer id", {doe, dout}, {1'b1, 16'h0097});
    cyc(0, 0, 0, 1, 1, '0);
    check("R8 device id", {doe, dout}, {1'b1, 16'h0030});
    cyc(0, 0, 0, 1, 6, '0);
    check("R8 manufacturer id bit0 low", {doe, dout}, {1'b1, 16'h0097});
    cyc(0, 0, 0, 1, 3, '0);
    check("R8 device id bit0 high", {doe, dout}, {1'b1, 16'h0030});

    cyc(1, 1, 0, 0, 0, '0);
    erase = 1'b1;
    @(negedge clk);
    erase = 1'b0;
    for (int a = 0; a < N; a++) begin
      cyc(0, 0, 0, 0, AW'(a), '0);
      check("R10 erasable reads blank", {doe, dout}, {1'b1, 16'hFFFF});
      check("R10 otp ignores erase", {doe_otp, dout_otp}, {1'b1, exp_mem[a]});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule